// File: doc/BRIEF.md
# Bit Count Unit

This unit takes a 64-bit operand and returns one of three counts: the number of leading zeros, the number of trailing zeros, or the number of set bits. A word-mode flag limits the count to the low 32-bit half of the operand. In that mode the upper half is ignored, and an empty low word gives 32.

The datapath has two trees. One tree finds the trailing-zero count. It handles leading zeros by first reversing the bit order. In word mode a block of ones is placed above bit 31, so the search stops at 32. The second tree is an adder tree that counts set bits. Each tree has depth log2 of the operand width. A single register stage follows the select logic, so the count appears on the output one clock after the operand is presented. The count is zero-extended to 64 bits.

Top module: `bit_count_unit`

## Requirements
- R1: With kind = 2'b00 and word mode low, the result is the number of zero bits above the most significant set bit of the 64-bit operand. An all-zero operand gives 64.
- R2: With kind = 2'b00 and word mode high, the result is the number of zero bits above the most significant set bit within operand bits [31:0]. A zero low word gives 32.
- R3: With kind = 2'b01 and word mode low, the result is the number of zero bits below the least significant set bit of the 64-bit operand. An all-zero operand gives 64.
- R4: With kind = 2'b01 and word mode high, the result is the trailing-zero count within operand bits [31:0]. A zero low word gives 32.
- R5: With kind = 2'b10 and word mode low, the result is the number of ones in the 64-bit operand.
- R6: With kind = 2'b10 and word mode high, the result is the number of ones in operand bits [31:0].
- R7: With word mode high, operand bits [63:32] have no effect on the result for any kind.
- R8: Result bits [63:7] are always zero, because the count is zero-extended.
- R9: kind = 2'b11 is reserved and gives a result of zero.
- R10: The result register loads the count of the inputs sampled at each rising clock edge. While rst_n is low, the result is held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| operand | input | 64 | Value to be counted |
| kind | input | 2 | Count type: 00 leading zeros, 01 trailing zeros, 10 set bits, 11 reserved |
| word_mode | input | 1 | When high, count only within bits [31:0] |
| result | output | 64 | Registered, zero-extended count |

## Verification
The assertions check, on every cycle, the outcomes that can be stated as fixed rules:
- an empty operand or empty low word gives 64 or 32;
- an all-ones operand gives the full set-bit count;
- a reserved kind gives zero;
- a word-mode result never exceeds 32;
- for a single set bit, the trailing count points at that bit.

General counts cannot be expressed as a simple property, so only the bench's scenarios show them. These scenarios are single-bit sweeps, random values compared against a loop-based reference, and word-mode operands with random upper halves. The bench also confirms that the result is zero while reset is asserted.

// File: rtl/bit_count_pkg.sv
package bit_count_pkg;
    typedef enum logic [1:0] {
        CNT_LEAD  = 2'b00,
        CNT_TRAIL = 2'b01,
        CNT_POP   = 2'b10,
        CNT_NONE  = 2'b11
    } cnt_kind_e;
endpackage

// File: rtl/bcu_operand_prep.sv
// Builds the vector for the trailing-zero search and the vector for the set-bit
// adder tree. A leading count becomes a trailing count on the reversed bits.
// In word mode, ones above the low word act as a sentinel that stops the search.
module bcu_operand_prep
    import bit_count_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WORD = 32
) (
    input  logic [XLEN-1:0] operand,
    input  cnt_kind_e       kind,
    input  logic            word_mode,
    output logic [XLEN-1:0] tz_vec,
    output logic [XLEN-1:0] pop_vec
);
    localparam int UPPER = XLEN - WORD;

    logic [XLEN-1:0] rev_full;
    logic [WORD-1:0] rev_word;

    for (genvar i = 0; i < XLEN; i++) begin : g_rev_full
        assign rev_full[i] = operand[XLEN-1-i];
    end
    for (genvar i = 0; i < WORD; i++) begin : g_rev_word
        assign rev_word[i] = operand[WORD-1-i];
    end

    always_comb begin
        unique case (kind)
            CNT_LEAD: tz_vec = word_mode ? {{UPPER{1'b1}}, rev_word} : rev_full;
            default:  tz_vec = word_mode ? {{UPPER{1'b1}}, operand[WORD-1:0]} : operand;
        endcase
    end

    assign pop_vec = word_mode ? {{UPPER{1'b0}}, operand[WORD-1:0]} : operand;
endmodule

// File: rtl/bcu_tz_tree.sv
// Trailing-zero counter laid out as a heap-indexed binary tree.
// Node k has children 2k (lower bits) and 2k+1 (upper bits).
// Leaf W+j holds bit j.
module bcu_tz_tree #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    logic          nz  [2*W];
    logic [CW-1:0] cnt [2*W];

    assign nz[0]  = 1'b0;
    assign cnt[0] = '0;

    for (genvar j = 0; j < W; j++) begin : g_leaf
        assign nz[W+j]  = vec[j];
        assign cnt[W+j] = '0;
    end

    for (genvar k = 1; k < W; k++) begin : g_node
        localparam int HALF = W >> $clog2(k + 1);
        assign nz[k]  = nz[2*k] | nz[2*k+1];
        assign cnt[k] = nz[2*k] ? cnt[2*k] : CW'(HALF) + cnt[2*k+1];
    end

    assign count = nz[1] ? cnt[1] : CW'(W);
endmodule

// File: rtl/bcu_pop_tree.sv
// Set-bit counter built as a balanced adder tree with the same heap indexing.
module bcu_pop_tree #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    logic [CW-1:0] sum [2*W];

    assign sum[0] = '0;

    for (genvar j = 0; j < W; j++) begin : g_leaf
        assign sum[W+j] = CW'(vec[j]);
    end

    for (genvar k = 1; k < W; k++) begin : g_node
        assign sum[k] = sum[2*k] + sum[2*k+1];
    end

    assign count = sum[1];
endmodule

// File: rtl/bit_count_unit.sv
module bit_count_unit
    import bit_count_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WORD = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] operand,
    input  logic [1:0]      kind,
    input  logic            word_mode,
    output logic [XLEN-1:0] result
);
    localparam int CW = $clog2(XLEN) + 1;

    cnt_kind_e       kind_e;
    logic [XLEN-1:0] tz_vec;
    logic [XLEN-1:0] pop_vec;
    logic [CW-1:0]   tz_count;
    logic [CW-1:0]   pop_count;
    logic [CW-1:0]   sel_count;
    logic            primed;

    assign kind_e = cnt_kind_e'(kind);

    bcu_operand_prep #(.XLEN(XLEN), .WORD(WORD)) u_prep (
        .operand  (operand),
        .kind     (kind_e),
        .word_mode(word_mode),
        .tz_vec   (tz_vec),
        .pop_vec  (pop_vec)
    );

    bcu_tz_tree #(.W(XLEN), .CW(CW)) u_tz (
        .vec  (tz_vec),
        .count(tz_count)
    );

    bcu_pop_tree #(.W(XLEN), .CW(CW)) u_pop (
        .vec  (pop_vec),
        .count(pop_count)
    );

    always_comb begin
        unique case (kind_e)
            CNT_LEAD, CNT_TRAIL: sel_count = tz_count;
            CNT_POP:             sel_count = pop_count;
            default:             sel_count = '0;
        endcase
    end

    // R10
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            primed <= 1'b0;
        end else begin
            result <= {{(XLEN-CW){1'b0}}, sel_count};
            primed <= 1'b1;
        end
    end

    // R1 R3
    full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(kind != 2'b11 && kind != 2'b10 && !word_mode && operand == '0))
        |-> (result == XLEN));

    // R2 R4
    word_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(kind != 2'b11 && kind != 2'b10 && word_mode && operand[WORD-1:0] == '0))
        |-> (result == WORD));

    // R5
    pop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(kind == 2'b10 && !word_mode && (&operand)))
        |-> (result == XLEN));

    // R9
    reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(kind == 2'b11)) |-> (result == '0));

    // R7
    word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(word_mode)) |-> (result <= WORD));

    // R3
    trail_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(kind == 2'b01 && !word_mode && $countones(operand) == 1))
        |-> ((($past(operand) >> result[CW-1:0]) & XLEN'(1)) == XLEN'(1)));
endmodule

// File: tb/bit_count_unit_test.sv
module bit_count_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  kind = 2'b00;
    logic        word_mode = 1'b0;
    logic [63:0] result;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    bit_count_unit uut (
        .clk(clk), .rst_n(rst_n), .operand(operand),
        .kind(kind), .word_mode(word_mode), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint unsigned ref_count(logic [63:0] op, logic [1:0] k, logic w);
        int width = w ? 32 : 64;
        int n = 0;
        case (k)
            2'b00: begin
                for (int i = width - 1; i >= 0; i--) begin
                    if (op[i]) break;
                    n++;
                end
            end
            2'b01: begin
                for (int i = 0; i < width; i++) begin
                    if (op[i]) break;
                    n++;
                end
            end
            2'b10: begin
                for (int i = 0; i < width; i++) n += int'(op[i]);
            end
            default: n = 0;
        endcase
        return longint'(n);
    endfunction

    function automatic string req_tag(logic [1:0] k, logic w);
        case (k)
            2'b00:   return w ? "R2/R7" : "R1";
            2'b01:   return w ? "R4/R7" : "R3";
            2'b10:   return w ? "R6/R7" : "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge. The rising edge loads the result (R10).
    // Compare at the next falling edge.
    task automatic step(logic [63:0] op, logic [1:0] k, logic w);
        logic [63:0] exp;
        operand = op;
        kind = k;
        word_mode = w;
        exp = ref_count(op, k, w);
        @(posedge clk);
        @(negedge clk);
        check({req_tag(k, w), " R10"}, result, exp);
        // R8
        check("R8", {result[63:7], 7'b0}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        operand = 64'hFFFF_FFFF_FFFF_FFFF;
        kind = 2'b10;
        repeat (3) @(negedge clk);
        // R10: reset holds the result at zero
        check("R10 reset", result, 64'd0);
        rst_n = 1'b1;

        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 2; w++) begin
                step(64'd0, 2'(k), 1'(w));
                step(64'hFFFF_FFFF_FFFF_FFFF, 2'(k), 1'(w));
            end
        end

        for (int k = 0; k < 3; k++) begin
            for (int w = 0; w < 2; w++) begin
                for (int b = 0; b < 64; b++) begin
                    step(64'd1 << b, 2'(k), 1'(w));
                end
            end
        end

        // R7: upper half set while the low word takes corner values
        for (int k = 0; k < 3; k++) begin
            step(64'hFFFF_FFFF_0000_0000, 2'(k), 1'b1);
            step(64'h8000_0000_0000_0001, 2'(k), 1'b1);
            step(64'h1234_5678_8000_0000, 2'(k), 1'b1);
        end

        for (int i = 0; i < 600; i++) begin
            logic [63:0] v = {$urandom, $urandom};
            if (i % 5 == 0) v = v >> ($urandom % 64);
            if (i % 7 == 0) v = v << ($urandom % 64);
            step(v, 2'($urandom % 4), 1'($urandom % 2));
        end

        // R10: a held input gives a steady result over several cycles
        step(64'h0000_0100_0000_0000, 2'b00, 1'b0);
        step(64'h0000_0100_0000_0000, 2'b00, 1'b0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule